// File: doc/BRIEF.md
# Two-Sided Doorbell Mailbox

This block lets two processors exchange short messages in both directions through a shared register file. Each side has its own register port and its own interrupt line. A sender puts a payload of up to `MSG_BYTES` bytes into its outbound message region. It then rings the outbound doorbell by writing a 32-bit word with the busy flag set. That word appears at once as the receiver's inbound doorbell and raises the receiver's interrupt.

The receiver reads the payload and hands the doorbell back by writing its inbound doorbell with the busy flag clear. That hand-back drops the receiver's interrupt. It also records a clear event on the sender's side, where a maskable interrupt reports it. The sender acknowledges the event with a write-one-to-clear. The doorbell word carries a length, a protocol, a command and option bits. The block checks only the length and gives no meaning to the rest.

Each port has an address, write data, a write enable, combinational read data and a level interrupt. The word address map of one side, with W = `MSG_BYTES`/4:
- 0..W-1: outbound message region (write, read back)
- W..2W-1: inbound message region (read only)
- 2W: outbound doorbell
- 2W+1: inbound doorbell
- 2W+2: interrupt status
- 2W+3: interrupt mask
- 2W+4: clear-event status

With the default of 128 bytes, W = 32 and these registers sit at word addresses 64 to 68.

Top module: `dbell_mailbox`

## Requirements
- R1: After reset every doorbell, status, mask and clear-event register reads zero, every message word reads zero, and both interrupts are low.
- R2: A write of a doorbell word with bit 31 set, while the outbound doorbell is idle and the length is valid, stores the whole word. The word reads back unchanged as the sender's outbound doorbell and as the peer's inbound doorbell. Its fields are: length in bits 9:0, protocol in bits 13:10, command in bits 19:16, options in bits 30:29, and busy in bit 31.
- R3: A ring whose length field (bits 9:0) exceeds `MSG_BYTES` is ignored, and the doorbell keeps its previous value.
- R4: While the outbound doorbell is busy, writes to that doorbell are ignored.
- R5: A word written into the sender's outbound region at index i reads back at index i of the peer's inbound region. Message-region writes are ignored while the outbound doorbell is busy.
- R6: The receiver clears the busy flag by writing its inbound doorbell with bit 31 at 0. Bits 30:0 of the doorbell are kept.
- R7: Bit 0 of the interrupt status register equals the inbound busy flag. The interrupt output goes high one cycle after a status bit and its mask bit are both 1. The mask bit for this event is bit 0.
- R8: When the peer clears a busy outbound doorbell, bit 0 of the clear-event status register is set. This bit drives the interrupt through mask bit 11. Writing 1 to bit 0 clears it, but a clear event in the same cycle wins over the write.
- R9: Only mask bits 0 and 11 can be written. All other mask bits read zero.
- R10: The two directions are independent and behave the same way. Traffic from B to A follows R2 to R8 with the sides swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_addr | input | ADDR_W | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_we | input | 1 | Side A write enable |
| a_rdata | output | 32 | Side A read data (combinational) |
| a_irq | output | 1 | Side A interrupt, level |
| b_addr | input | ADDR_W | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_we | input | 1 | Side B write enable |
| b_rdata | output | 32 | Side B read data (combinational) |
| b_irq | output | 1 | Side B interrupt, level |

## Verification
The bench builds the block with the default of 128 bytes, so W is 32 and the registers sit at word addresses 64 to 68. With this size a length of exactly 128 is accepted and 129 is rejected, so both sides of the R3 limit are checked. Message index 31, the last word of the region, is also exercised. Because both sides can be driven in the same cycle, the bench can provoke the set-versus-clear collision of the clear-event bit.

// File: rtl/dbell_pkg.sv
// Package: bit positions of the doorbell word and the mask register.
// Assumes a 32-bit data path on both register ports.
package dbell_pkg;
    localparam int DATA_W      = 32;
    localparam int BUSY_BIT    = 31;
    localparam int LEN_LSB     = 0;
    localparam int LEN_W       = 10;
    localparam int MASK_IN_BIT = 0;
    localparam int MASK_CLR_BIT = 11;
    localparam logic [DATA_W-1:0] MASK_LEGAL =
        (32'd1 << MASK_IN_BIT) | (32'd1 << MASK_CLR_BIT);
endpackage

// File: rtl/dbell_channel.sv
// One direction of the mailbox: payload store, doorbell word and clear event.
// Assumes MSG_BYTES is a power of two, at least 8 and at most 1023.
// The sender writes the payload and rings; the receiver clears busy.
module dbell_channel
    import dbell_pkg::*;
#(
    parameter int MSG_BYTES = 128,
    parameter int MSG_WORDS = MSG_BYTES / 4,
    parameter int IDX_W     = $clog2(MSG_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_msg_we,
    input  logic              snd_db_we,
    input  logic [IDX_W-1:0]  snd_idx,
    input  logic [DATA_W-1:0] snd_wdata,
    input  logic              rcv_db_we,
    input  logic              rcv_busy_wr,
    input  logic [IDX_W-1:0]  rcv_idx,
    output logic [DATA_W-1:0] doorbell,
    output logic [DATA_W-1:0] snd_word,
    output logic [DATA_W-1:0] rcv_word,
    output logic              clr_evt
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MSG_BYTES);

    logic [DATA_W-1:0] mem [MSG_WORDS];
    logic              busy;
    logic              ring_ok;
    logic              idle_wr;

    assign busy     = doorbell[BUSY_BIT];
    assign snd_word = mem[snd_idx];
    assign rcv_word = mem[rcv_idx];

    // Accept a doorbell write only when idle; refuse a ring with an oversize length.
    assign ring_ok = !(snd_wdata[BUSY_BIT] && (snd_wdata[LEN_LSB +: LEN_W] > MAX_LEN));
    assign idle_wr = snd_db_we && !busy && ring_ok;
    // A clear event is the receiver returning a busy doorbell.
    assign clr_evt = rcv_db_we && busy && !rcv_busy_wr;

    // Payload store: written by the sender only while the doorbell is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MSG_WORDS; i++) mem[i] <= '0;
        end else if (snd_msg_we && !busy) begin
            mem[snd_idx] <= snd_wdata;
        end
    end

    // Doorbell word: loaded by the sender when idle, busy dropped by the receiver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            doorbell <= '0;
        end else if (idle_wr) begin
            doorbell <= snd_wdata;
        end else if (clr_evt) begin
            doorbell[BUSY_BIT] <= 1'b0;
        end
    end

    AST_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_db_we && !busy && snd_wdata[BUSY_BIT] && snd_wdata[LEN_LSB +: LEN_W] > MAX_LEN)
        |=> !doorbell[BUSY_BIT]); // R3
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(rcv_db_we && !rcv_busy_wr)) |=> $stable(doorbell)); // R4
    AST_MSG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && snd_msg_we) |=> (mem[$past(snd_idx)] == $past(snd_word))); // R5
    AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> (!doorbell[BUSY_BIT] && doorbell[BUSY_BIT-1:0] == $past(doorbell[BUSY_BIT-1:0]))); // R6
endmodule

// File: rtl/dbell_side.sv
// One processor's port: address decode, read mux, mask, clear-event status
// and the registered interrupt. Assumes MSG_BYTES is a power of two.
module dbell_side
    import dbell_pkg::*;
#(
    parameter int MSG_BYTES = 128,
    parameter int MSG_WORDS = MSG_BYTES / 4,
    parameter int IDX_W     = $clog2(MSG_WORDS),
    parameter int ADDR_W    = $clog2(2 * MSG_WORDS + 5)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic [DATA_W-1:0] out_db,
    input  logic [DATA_W-1:0] in_db,
    input  logic [DATA_W-1:0] out_word,
    input  logic [DATA_W-1:0] in_word,
    input  logic              clr_evt,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              msg_we,
    output logic              db_we,
    output logic              in_db_we,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] IN_BASE  = ADDR_W'(MSG_WORDS);
    localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'(2 * MSG_WORDS);
    localparam logic [ADDR_W-1:0] A_DBO  = REG_BASE;
    localparam logic [ADDR_W-1:0] A_DBI  = REG_BASE + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_STAT = REG_BASE + ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_MASK = REG_BASE + ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_CLR  = REG_BASE + ADDR_W'(4);

    logic [DATA_W-1:0] mask_q;
    logic              clr_q;
    logic              in_busy;

    assign in_busy  = in_db[BUSY_BIT];
    assign idx      = addr[IDX_W-1:0];
    assign msg_we   = we && (addr < IN_BASE);
    assign db_we    = we && (addr == A_DBO);
    assign in_db_we = we && (addr == A_DBI);

    // Read mux over both message regions and the five registers.
    always_comb begin
        rdata = '0;
        if (addr < IN_BASE)       rdata = out_word;
        else if (addr < REG_BASE) rdata = in_word;
        else if (addr == A_DBO)   rdata = out_db;
        else if (addr == A_DBI)   rdata = in_db;
        else if (addr == A_STAT)  rdata = {{(DATA_W-1){1'b0}}, in_busy};
        else if (addr == A_MASK)  rdata = mask_q;
        else if (addr == A_CLR)   rdata = {{(DATA_W-1){1'b0}}, clr_q};
    end

    // Mask register: only the two gate bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)                    mask_q <= '0;
        else if (we && addr == A_MASK) mask_q <= wdata & MASK_LEGAL;
    end

    // Clear-event status: set by the peer's clear, write-one-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                               clr_q <= 1'b0;
        else if (clr_evt)                         clr_q <= 1'b1;
        else if (we && addr == A_CLR && wdata[0]) clr_q <= 1'b0;
    end

    // Interrupt: registered OR of the gated events.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (in_busy && mask_q[MASK_IN_BIT]) || (clr_q && mask_q[MASK_CLR_BIT]);
    end

    AST_CLR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> clr_q); // R8
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_busy && mask_q[MASK_IN_BIT]) |=> irq); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq); // R7
endmodule

// File: rtl/dbell_mailbox.sv
// Top: two register ports, two one-way channels. Channel d carries traffic
// from side d to side 1-d. Assumes MSG_BYTES is a power of two.
module dbell_mailbox
    import dbell_pkg::*;
#(
    parameter int MSG_BYTES = 128,
    parameter int ADDR_W    = $clog2(2 * (MSG_BYTES / 4) + 5)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [31:0]       a_wdata,
    input  logic              a_we,
    output logic [31:0]       a_rdata,
    output logic              a_irq,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [31:0]       b_wdata,
    input  logic              b_we,
    output logic [31:0]       b_rdata,
    output logic              b_irq
);
    localparam int MSG_WORDS = MSG_BYTES / 4;
    localparam int IDX_W     = $clog2(MSG_WORDS);

    logic [ADDR_W-1:0] s_addr  [2];
    logic [DATA_W-1:0] s_wdata [2];
    logic              s_we    [2];
    logic [DATA_W-1:0] s_rdata [2];
    logic              s_irq   [2];
    logic              s_msg_we[2];
    logic              s_db_we [2];
    logic              s_in_we [2];
    logic [IDX_W-1:0]  s_idx   [2];
    logic [DATA_W-1:0] c_db    [2];
    logic [DATA_W-1:0] c_sword [2];
    logic [DATA_W-1:0] c_rword [2];
    logic              c_clr   [2];

    assign s_addr[0]  = a_addr;
    assign s_wdata[0] = a_wdata;
    assign s_we[0]    = a_we;
    assign s_addr[1]  = b_addr;
    assign s_wdata[1] = b_wdata;
    assign s_we[1]    = b_we;
    assign a_rdata    = s_rdata[0];
    assign a_irq      = s_irq[0];
    assign b_rdata    = s_rdata[1];
    assign b_irq      = s_irq[1];

    for (genvar d = 0; d < 2; d++) begin : g_dir
        dbell_channel #(.MSG_BYTES(MSG_BYTES)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .snd_msg_we (s_msg_we[d]),
            .snd_db_we  (s_db_we[d]),
            .snd_idx    (s_idx[d]),
            .snd_wdata  (s_wdata[d]),
            .rcv_db_we  (s_in_we[1-d]),
            .rcv_busy_wr(s_wdata[1-d][BUSY_BIT]),
            .rcv_idx    (s_idx[1-d]),
            .doorbell   (c_db[d]),
            .snd_word   (c_sword[d]),
            .rcv_word   (c_rword[d]),
            .clr_evt    (c_clr[d])
        );

        dbell_side #(.MSG_BYTES(MSG_BYTES), .ADDR_W(ADDR_W)) u_side (
            .clk     (clk),
            .rst_n   (rst_n),
            .addr    (s_addr[d]),
            .wdata   (s_wdata[d]),
            .we      (s_we[d]),
            .out_db  (c_db[d]),
            .in_db   (c_db[1-d]),
            .out_word(c_sword[d]),
            .in_word (c_rword[1-d]),
            .clr_evt (c_clr[d]),
            .rdata   (s_rdata[d]),
            .irq     (s_irq[d]),
            .msg_we  (s_msg_we[d]),
            .db_we   (s_db_we[d]),
            .in_db_we(s_in_we[d]),
            .idx     (s_idx[d])
        );
    end
endmodule

// File: tb/tb_dbell_mailbox.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_dbell_mailbox;
    localparam int MB  = 128;
    localparam int MW  = MB / 4;
    localparam int AW  = $clog2(2 * MW + 5);
    localparam logic [AW-1:0] DBO  = AW'(2 * MW);
    localparam logic [AW-1:0] DBI  = AW'(2 * MW + 1);
    localparam logic [AW-1:0] STAT = AW'(2 * MW + 2);
    localparam logic [AW-1:0] MSK  = AW'(2 * MW + 3);
    localparam logic [AW-1:0] CLR  = AW'(2 * MW + 4);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic a_we = 1'b0, b_we = 1'b0;
    logic [31:0] a_rdata, b_rdata;
    logic a_irq, b_irq;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    dbell_mailbox #(.MSG_BYTES(MB)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_rdata(a_rdata), .a_irq(a_irq),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_rdata(b_rdata), .b_irq(b_irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write one word on side 0 (A) or 1 (B); returns at the following negedge.
    task automatic wr(int s, logic [AW-1:0] ad, logic [31:0] d);
        @(negedge clk);
        if (s == 0) begin a_addr = ad; a_wdata = d; a_we = 1'b1; end
        else        begin b_addr = ad; b_wdata = d; b_we = 1'b1; end
        @(negedge clk);
        a_we = 1'b0; b_we = 1'b0;
    endtask

    // Write on both sides in the same cycle.
    task automatic wr2(logic [AW-1:0] aa, logic [31:0] ad, logic [AW-1:0] ba, logic [31:0] bd);
        @(negedge clk);
        a_addr = aa; a_wdata = ad; a_we = 1'b1;
        b_addr = ba; b_wdata = bd; b_we = 1'b1;
        @(negedge clk);
        a_we = 1'b0; b_we = 1'b0;
    endtask

    task automatic rd(int s, logic [AW-1:0] ad, output logic [31:0] v);
        if (s == 0) a_addr = ad; else b_addr = ad;
        #1;
        v = (s == 0) ? a_rdata : b_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, DBO, v);  check("R1 a dbo", v, 0);
        rd(1, DBI, v);  check("R1 b dbi", v, 0);
        rd(0, STAT, v); check("R1 a stat", v, 0);
        rd(1, MSK, v);  check("R1 b mask", v, 0);
        rd(0, CLR, v);  check("R1 a clr", v, 0);
        rd(1, AW'(MW), v); check("R1 b in word0", v, 0);
        rd(0, AW'(MW - 1), v); check("R1 a out word31", v, 0);
        check("R1 a irq", {31'd0, a_irq}, 0);
        check("R1 b irq", {31'd0, b_irq}, 0);
    endtask

    task automatic t_ring();
        logic [31:0] v;
        wr(1, MSK, 32'h1);
        wr(0, MSK, 32'h800);
        wr(0, AW'(0), 32'h1111_1111);
        wr(0, AW'(MW - 1), 32'hA5A5_5A5A);
        wr(0, DBO, 32'hC005_1080);  // len 128, proto 4, cmd 5, opt 2, busy
        check("R7 b irq lags status", {31'd0, b_irq}, 0);
        rd(1, DBI, v);  check("R2 b inbound doorbell", v, 32'hC005_1080);
        rd(0, DBO, v);  check("R2 a outbound doorbell", v, 32'hC005_1080);
        rd(1, STAT, v); check("R7 b status", v, 1);
        @(negedge clk);
        check("R7 b irq high", {31'd0, b_irq}, 1);
        rd(1, AW'(MW), v); check("R5 b in word0", v, 32'h1111_1111);
        rd(1, AW'(2 * MW - 1), v); check("R5 b in word31", v, 32'hA5A5_5A5A);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        wr(0, AW'(0), 32'h2222_2222);
        wr(0, DBO, 32'h8000_0004);
        rd(1, AW'(MW), v); check("R5 msg write while busy ignored", v, 32'h1111_1111);
        rd(0, AW'(0), v);  check("R5 a out word0 unchanged", v, 32'h1111_1111);
        rd(1, DBI, v);     check("R4 doorbell write while busy ignored", v, 32'hC005_1080);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(1, DBI, 32'h0);
        rd(0, DBO, v);  check("R6 busy cleared fields kept", v, 32'h4005_1080);
        rd(1, STAT, v); check("R7 b status low", v, 0);
        rd(0, CLR, v);  check("R8 a clear event set", v, 1);
        @(negedge clk);
        check("R7 b irq low", {31'd0, b_irq}, 0);
        check("R8 a irq on clear event", {31'd0, a_irq}, 1);
        wr(0, CLR, 32'h1);
        rd(0, CLR, v);  check("R8 w1c clears", v, 0);
        @(negedge clk);
        check("R8 a irq drops", {31'd0, a_irq}, 0);
    endtask

    task automatic t_len();
        logic [31:0] v;
        wr(0, DBO, 32'h8000_0081);  // length 129
        rd(0, DBO, v);  check("R3 oversize ring ignored", v, 32'h4005_1080);
        rd(1, STAT, v); check("R3 b status stays low", v, 0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(0, MSK, 32'hFFFF_FFFF);
        rd(0, MSK, v); check("R9 only bits 0 and 11", v, 32'h0000_0801);
        wr(0, MSK, 32'h0);
        rd(0, MSK, v); check("R9 mask cleared", v, 0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        wr(0, DBO, 32'h8000_0004);
        wr2(CLR, 32'h1, DBI, 32'h0);
        rd(0, CLR, v); check("R8 set wins over w1c", v, 1);
        @(negedge clk);
        check("R8 masked clear event keeps irq low", {31'd0, a_irq}, 0);
        wr(0, CLR, 32'h1);
        rd(0, CLR, v); check("R8 w1c after collision", v, 0);
    endtask

    task automatic t_reverse();
        logic [31:0] v;
        wr(0, MSK, 32'h1);
        wr(1, MSK, 32'h800);
        wr(1, AW'(3), 32'hDEAD_BEEF);
        wr(1, DBO, 32'h8000_0010);
        rd(0, DBI, v);  check("R10 a inbound doorbell", v, 32'h8000_0010);
        rd(0, AW'(MW + 3), v); check("R10 a in word3", v, 32'hDEAD_BEEF);
        rd(0, STAT, v); check("R10 a status", v, 1);
        @(negedge clk);
        check("R10 a irq", {31'd0, a_irq}, 1);
        wr(0, DBI, 32'h0);
        rd(1, DBO, v);  check("R10 b doorbell cleared", v, 32'h0000_0010);
        rd(1, CLR, v);  check("R10 b clear event", v, 1);
        @(negedge clk);
        check("R10 b irq", {31'd0, b_irq}, 1);
        check("R10 a irq low", {31'd0, a_irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ring();
        t_busy_ignore();
        t_clear();
        t_len();
        t_mask();
        t_set_wins();
        t_reverse();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule